// File: doc/BRIEF.md
# Hidden Configuration Register Unlock Decoder

This block watches a byte-addressed I/O window that normally carries the task-file registers of a disk drive. It forwards every access to the drive unless a short key sequence has opened a hidden configuration space. The key is two word reads at offset 1 followed by a byte write of 3 at offset 2. After the key, byte accesses at a small set of offsets reach internal configuration registers and do not reach the drive. A byte write of 0x83 at offset 2 closes the space again.

The configuration space holds two banks of read and write cycle timing bytes, a control byte, a miscellaneous byte and a read-only strap byte. A timing generator outside this block consumes these values. Software picks the bank through the miscellaneous byte. The second bank can only be reached after a dedicated arming write made while the window is closed. A control value of 0x85 turns on split timing, where each of the two drives uses its own bank.

Top module: `hidden_cfg_decoder`

## Requirements
- R1: The window opens after two consecutive word reads at offset 1 are followed by a byte write of 0x03 at offset 2. More than two such reads still count, and cycles with no access are ignored. The access in the next cycle is decoded as open.
- R2: Any other access made before the key completes returns the detector to its start state.
- R3: While the window is open, a byte access at offset 0 (read timing), 1 (write timing), 3 (control), 5 (strap) or 6 (miscellaneous) is captured and raises neither drive strobe. A captured read returns {8'h00, register} on io_rdata_o in the same cycle. A captured write stores the data byte at the clock edge and pulses cfg_wen_o: bit 0 for read timing, bit 1 for write timing, bit 2 for control, bit 3 for miscellaneous. Word accesses and other offsets pass through to the drive.
- R4: While the window is open, a byte write of 0x83 at offset 2 closes it and is not forwarded. Other accesses at offset 2 are forwarded.
- R5: Bit 0 of the strap byte is strap_clk_i (1 = 25 MHz bus, 0 = 33 MHz) and bits 7:1 read 0. Writes to offset 5 are captured and change nothing, and they pulse no cfg_wen_o bit.
- R6: While the window is closed, every access is forwarded to drv_rd_o/drv_wr_o, and io_rdata_o equals drv_rdata_i. No configuration register changes, apart from the arming described in R8.
- R7: A miscellaneous write stores the full byte. If the value is 0 or 1, it also selects timing bank A (0) or bank B (1). Any other value leaves the bank selection unchanged.
- R8: A byte write of 0xC0 at offset 3 while the window is closed arms bank B. The write is still forwarded, and the arming holds until reset. Timing accesses reach bank B only when bank B is armed and selected; otherwise they reach bank A. tim_rd_o and tim_wr_o carry bank A in bits 7:0 and bank B in bits 15:8.
- R9: A control write of 0x85 sets split_o. A control write of any other value clears it.
- R10: After reset the window is closed, bank A is selected, bank B is not armed, and all configuration registers and split_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 3 | Offset within the I/O window |
| io_rd_i | input | 1 | Read strobe, one cycle per access |
| io_wr_i | input | 1 | Write strobe, one cycle per access |
| io_word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_wdata_i | input | 8 | Write data byte |
| io_rdata_o | output | 16 | Read data returned to the host |
| strap_clk_i | input | 1 | Bus clock strap, 1 = 25 MHz |
| drv_rd_o | output | 1 | Read strobe forwarded to the drive |
| drv_wr_o | output | 1 | Write strobe forwarded to the drive |
| drv_rdata_i | input | 16 | Read data from the drive |
| cfg_wen_o | output | 4 | Configuration write enables |
| tim_rd_o | output | 16 | Read timing bytes, bank B above bank A |
| tim_wr_o | output | 16 | Write timing bytes, bank B above bank A |
| ctrl_o | output | 8 | Control byte |
| misc_o | output | 8 | Miscellaneous byte |
| split_o | output | 1 | Split timing enable |

## Verification
Two functions can act in the same cycle when the window is closed and a byte write of 0xC0 at offset 3 arrives in the middle of a partly entered key. That one write both arms bank B and breaks the key sequence. The bench issues this write directly after an aborted key, then re-enters a full key with a third redundant word read. It then judges the outcome at the ports: the write is forwarded to the drive, the window opens only on the complete key, and timing writes land in bank B once that bank is selected. A second pair is a locked write to a configuration offset next to the same offset while open; it is judged by reading the byte back after the window opens.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ONE,
    SEQ_TWO,
    SEQ_OPEN
  } seq_e;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_RDT,
    TGT_WRT,
    TGT_CTL,
    TGT_STR,
    TGT_MSC
  } tgt_e;

  localparam logic [2:0] OFS_RDT = 3'd0;
  localparam logic [2:0] OFS_WRT = 3'd1;
  localparam logic [2:0] OFS_KEY = 3'd2;
  localparam logic [2:0] OFS_CTL = 3'd3;
  localparam logic [2:0] OFS_STR = 3'd5;
  localparam logic [2:0] OFS_MSC = 3'd6;

  localparam int WEN_W = 4;

endpackage

// File: rtl/hcfg_seq_fsm.sv
module hcfg_seq_fsm
  import hcfg_pkg::*;
#(
  parameter int         ADDR_W     = 3,
  parameter int         REG_W      = 8,
  parameter logic [2:0] PROBE_OFS  = 3'd1,
  parameter logic [7:0] KEY_VAL    = 8'h03,
  parameter logic [7:0] RELOCK_VAL = 8'h83
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic              open_o,
  output logic              relock_o
);

  seq_e state_q, state_d;
  logic acc, probe, key;

  assign acc      = rd_i | wr_i;
  assign probe    = rd_i & word_i & (addr_i == ADDR_W'(PROBE_OFS));
  assign key      = wr_i & ~word_i & (addr_i == ADDR_W'(OFS_KEY)) & (wdata_i == REG_W'(KEY_VAL));
  assign relock_o = (state_q == SEQ_OPEN) & wr_i & ~word_i &
                    (addr_i == ADDR_W'(OFS_KEY)) & (wdata_i == REG_W'(RELOCK_VAL));
  assign open_o   = (state_q == SEQ_OPEN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (acc) state_d = probe ? SEQ_ONE : SEQ_IDLE;
      SEQ_ONE:  if (acc) state_d = probe ? SEQ_TWO : SEQ_IDLE;
      SEQ_TWO:  if (acc) state_d = key ? SEQ_OPEN : (probe ? SEQ_TWO : SEQ_IDLE);
      SEQ_OPEN: if (relock_o) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assert_open_after_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(state_q == SEQ_TWO && key));

  assert_relock_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_o |=> !open_o);

  assert_abort_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_ONE && acc && !probe) |=> state_q == SEQ_IDLE);

endmodule

// File: rtl/hcfg_regfile.sv
module hcfg_regfile
  import hcfg_pkg::*;
#(
  parameter int         REG_W     = 8,
  parameter int         NUM_SETS  = 2,
  parameter logic [7:0] SPLIT_VAL = 8'h85
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  tgt_e                      tgt_i,
  input  logic                      we_i,
  input  logic [REG_W-1:0]          wdata_i,
  input  logic                      alt_arm_i,
  output logic [WEN_W-1:0]          wen_o,
  output logic [NUM_SETS*REG_W-1:0] tim_rd_o,
  output logic [NUM_SETS*REG_W-1:0] tim_wr_o,
  output logic [REG_W-1:0]          sel_rd_o,
  output logic [REG_W-1:0]          sel_wr_o,
  output logic [REG_W-1:0]          ctrl_o,
  output logic [REG_W-1:0]          misc_o,
  output logic                      split_o
);

  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

  logic [REG_W-1:0] rd_q [NUM_SETS];
  logic [REG_W-1:0] wr_q [NUM_SETS];
  logic [REG_W-1:0] ctrl_q, misc_q;
  logic [SET_W-1:0] bank_q, cur_set;
  logic             alt_en_q, split_q, bank_ok;

  always_comb begin
    wen_o    = '0;
    wen_o[0] = we_i & (tgt_i == TGT_RDT);
    wen_o[1] = we_i & (tgt_i == TGT_WRT);
    wen_o[2] = we_i & (tgt_i == TGT_CTL);
    wen_o[3] = we_i & (tgt_i == TGT_MSC);
  end

  assign cur_set = alt_en_q ? bank_q : '0;
  assign bank_ok = ({{(32-REG_W){1'b0}}, wdata_i} < NUM_SETS);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rd_q[s] <= '0;
        wr_q[s] <= '0;
      end else begin
        if (wen_o[0] && cur_set == SET_W'(s)) rd_q[s] <= wdata_i;
        if (wen_o[1] && cur_set == SET_W'(s)) wr_q[s] <= wdata_i;
      end
    end
    assign tim_rd_o[s*REG_W +: REG_W] = rd_q[s];
    assign tim_wr_o[s*REG_W +: REG_W] = wr_q[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      misc_q   <= '0;
      bank_q   <= '0;
      alt_en_q <= 1'b0;
      split_q  <= 1'b0;
    end else begin
      if (alt_arm_i) alt_en_q <= 1'b1;
      if (wen_o[2]) begin
        ctrl_q  <= wdata_i;
        split_q <= (wdata_i == REG_W'(SPLIT_VAL));
      end
      if (wen_o[3]) begin
        misc_q <= wdata_i;
        if (bank_ok) bank_q <= wdata_i[SET_W-1:0];
      end
    end
  end

  assign sel_rd_o = rd_q[cur_set];
  assign sel_wr_o = wr_q[cur_set];
  assign ctrl_o   = ctrl_q;
  assign misc_o   = misc_q;
  assign split_o  = split_q;

  assert_single_wen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wen_o));

  assert_hold_without_wen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wen_o == '0) |=> ($stable(tim_rd_o) && $stable(tim_wr_o) && $stable(ctrl_o) && $stable(misc_o)));

  assert_split_on_ctrl_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_o[2] |=> $stable(split_o));

endmodule

// File: rtl/hcfg_rdmux.sv
module hcfg_rdmux
  import hcfg_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  tgt_e             tgt_i,
  input  logic [REG_W-1:0] sel_rd_i,
  input  logic [REG_W-1:0] sel_wr_i,
  input  logic [REG_W-1:0] ctrl_i,
  input  logic [REG_W-1:0] misc_i,
  input  logic             strap_i,
  output logic [REG_W-1:0] byte_o
);

  always_comb begin
    unique case (tgt_i)
      TGT_RDT: byte_o = sel_rd_i;
      TGT_WRT: byte_o = sel_wr_i;
      TGT_CTL: byte_o = ctrl_i;
      TGT_STR: byte_o = {{(REG_W-1){1'b0}}, strap_i};
      TGT_MSC: byte_o = misc_i;
      default: byte_o = '0;
    endcase
  end

endmodule

// File: rtl/hidden_cfg_decoder.sv
module hidden_cfg_decoder
  import hcfg_pkg::*;
#(
  parameter int         ADDR_W     = 3,
  parameter int         DATA_W     = 16,
  parameter int         REG_W      = 8,
  parameter int         NUM_SETS   = 2,
  parameter logic [7:0] KEY_VAL    = 8'h03,
  parameter logic [7:0] RELOCK_VAL = 8'h83,
  parameter logic [7:0] ARM_VAL    = 8'hC0,
  parameter logic [7:0] SPLIT_VAL  = 8'h85
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         io_addr_i,
  input  logic                      io_rd_i,
  input  logic                      io_wr_i,
  input  logic                      io_word_i,
  input  logic [REG_W-1:0]          io_wdata_i,
  output logic [DATA_W-1:0]         io_rdata_o,
  input  logic                      strap_clk_i,
  output logic                      drv_rd_o,
  output logic                      drv_wr_o,
  input  logic [DATA_W-1:0]         drv_rdata_i,
  output logic [WEN_W-1:0]          cfg_wen_o,
  output logic [NUM_SETS*REG_W-1:0] tim_rd_o,
  output logic [NUM_SETS*REG_W-1:0] tim_wr_o,
  output logic [REG_W-1:0]          ctrl_o,
  output logic [REG_W-1:0]          misc_o,
  output logic                      split_o
);

  logic             cfg_open, relock, hit, alt_arm, byte_acc;
  tgt_e             tgt;
  logic [REG_W-1:0] sel_rd, sel_wr, cfg_byte;

  hcfg_seq_fsm #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .PROBE_OFS(OFS_WRT),
    .KEY_VAL(KEY_VAL), .RELOCK_VAL(RELOCK_VAL)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(io_rd_i), .wr_i(io_wr_i),
    .word_i(io_word_i), .addr_i(io_addr_i), .wdata_i(io_wdata_i),
    .open_o(cfg_open), .relock_o(relock)
  );

  assign byte_acc = (io_rd_i | io_wr_i) & ~io_word_i;

  always_comb begin
    tgt = TGT_NONE;
    if (cfg_open && byte_acc) begin
      unique case (io_addr_i)
        ADDR_W'(OFS_RDT): tgt = TGT_RDT;
        ADDR_W'(OFS_WRT): tgt = TGT_WRT;
        ADDR_W'(OFS_CTL): tgt = TGT_CTL;
        ADDR_W'(OFS_STR): tgt = TGT_STR;
        ADDR_W'(OFS_MSC): tgt = TGT_MSC;
        default:          tgt = TGT_NONE;
      endcase
    end
  end

  assign hit     = (tgt != TGT_NONE);
  assign alt_arm = ~cfg_open & io_wr_i & ~io_word_i &
                   (io_addr_i == ADDR_W'(OFS_CTL)) & (io_wdata_i == REG_W'(ARM_VAL));

  hcfg_regfile #(
    .REG_W(REG_W), .NUM_SETS(NUM_SETS), .SPLIT_VAL(SPLIT_VAL)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .tgt_i(tgt), .we_i(io_wr_i & hit),
    .wdata_i(io_wdata_i), .alt_arm_i(alt_arm), .wen_o(cfg_wen_o),
    .tim_rd_o(tim_rd_o), .tim_wr_o(tim_wr_o), .sel_rd_o(sel_rd), .sel_wr_o(sel_wr),
    .ctrl_o(ctrl_o), .misc_o(misc_o), .split_o(split_o)
  );

  hcfg_rdmux #(.REG_W(REG_W)) u_rdmux (
    .tgt_i(tgt), .sel_rd_i(sel_rd), .sel_wr_i(sel_wr), .ctrl_i(ctrl_o),
    .misc_i(misc_o), .strap_i(strap_clk_i), .byte_o(cfg_byte)
  );

  assign drv_rd_o   = io_rd_i & ~hit;
  assign drv_wr_o   = io_wr_i & ~hit & ~relock;
  assign io_rdata_o = (io_rd_i & hit) ? {{(DATA_W-REG_W){1'b0}}, cfg_byte} : drv_rdata_i;

  assert_locked_passthru_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open && io_rd_i) |-> (drv_rd_o && io_rdata_o == drv_rdata_i));

  assert_cfg_write_not_forwarded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wen_o != '0) |-> !drv_wr_o);

  assert_strap_readback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open && io_rd_i && !io_word_i && io_addr_i == ADDR_W'(OFS_STR))
      |-> io_rdata_o == {{(DATA_W-1){1'b0}}, strap_clk_i});

endmodule

// File: tb/test_hidden_cfg_decoder.sv
module test_hidden_cfg_decoder;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic        word;
    logic [2:0]  addr;
    logic [7:0]  wd;
    logic [15:0] rdat;
    logic        drd;
    logic        dwr;
    logic [3:0]  wen;
    logic        split;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 37;
  localparam logic [15:0] DRV = 16'hBEEF;
  // rd wr word addr wd rdat drd dwr wen split req
  localparam vec_t VECS [NV] = '{
    '{1,0,1,1,'h00,'hBEEF,1,0,0,0,6},  // R6 locked forward
    '{1,0,1,1,'h00,'hBEEF,1,0,0,0,1},
    '{0,1,0,2,'h03,'h0000,0,1,0,0,1},  // R1 key, forwarded
    '{0,1,0,0,'h5A,'h0000,0,0,1,0,3},  // R3
    '{1,0,0,0,'h00,'h005A,0,0,0,0,3},
    '{0,1,0,3,'h85,'h0000,0,0,4,0,3},
    '{1,0,0,3,'h00,'h0085,0,0,0,1,9},  // R9
    '{1,0,0,5,'h00,'h0001,0,0,0,1,5},  // R5
    '{0,1,0,5,'h77,'h0000,0,0,0,1,5},
    '{1,0,0,5,'h00,'h0001,0,0,0,1,5},
    '{1,0,1,0,'h00,'hBEEF,1,0,0,1,3},  // word passes
    '{1,0,0,2,'h00,'hBEEF,1,0,0,1,4},  // R4
    '{0,1,0,2,'h83,'h0000,0,0,0,1,4},
    '{1,0,0,0,'h00,'hBEEF,1,0,0,1,4},
    '{0,1,0,0,'h11,'h0000,0,1,0,1,6},
    '{1,0,1,1,'h00,'hBEEF,1,0,0,1,2},  // R2 broken key
    '{1,0,0,1,'h00,'hBEEF,1,0,0,1,2},
    '{1,0,1,1,'h00,'hBEEF,1,0,0,1,2},
    '{0,1,0,2,'h03,'h0000,0,1,0,1,2},
    '{1,0,0,0,'h00,'hBEEF,1,0,0,1,2},
    '{0,1,0,3,'hC0,'h0000,0,1,0,1,8},  // R8 arm
    '{1,0,1,1,'h00,'hBEEF,1,0,0,1,1},
    '{1,0,1,1,'h00,'hBEEF,1,0,0,1,1},
    '{1,0,1,1,'h00,'hBEEF,1,0,0,1,1},
    '{0,1,0,2,'h03,'h0000,0,1,0,1,1},
    '{1,0,0,0,'h00,'h005A,0,0,0,1,6},
    '{0,1,0,6,'h01,'h0000,0,0,8,1,7},  // R7
    '{0,1,0,0,'hA1,'h0000,0,0,1,1,8},
    '{0,1,0,1,'hB2,'h0000,0,0,2,1,8},
    '{1,0,0,0,'h00,'h00A1,0,0,0,1,8},
    '{0,1,0,6,'h30,'h0000,0,0,8,1,7},
    '{1,0,0,1,'h00,'h00B2,0,0,0,1,7},
    '{1,0,0,6,'h00,'h0030,0,0,0,1,7},
    '{0,1,0,6,'h00,'h0000,0,0,8,1,7},
    '{1,0,0,0,'h00,'h005A,0,0,0,1,8},
    '{1,0,0,1,'h00,'h0000,0,0,0,1,8},
    '{0,1,0,3,'h07,'h0000,0,0,4,1,9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0, word = 1'b0, strap = 1'b1;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata, tim_rd, tim_wr;
  logic        drd, dwr, split;
  logic [3:0]  wen;
  logic [7:0]  ctrl, misc;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  hidden_cfg_decoder i_hidden_cfg_decoder (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_rd_i(rd), .io_wr_i(wr),
    .io_word_i(word), .io_wdata_i(wdata), .io_rdata_o(rdata), .strap_clk_i(strap),
    .drv_rd_o(drd), .drv_wr_o(dwr), .drv_rdata_i(DRV), .cfg_wen_o(wen),
    .tim_rd_o(tim_rd), .tim_wr_o(tim_wr), .ctrl_o(ctrl), .misc_o(misc), .split_o(split)
  );

  task automatic chk(input int req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic acc(input logic r, input logic w, input logic wd_word, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    rd = r; wr = w; word = wd_word; addr = a; wdata = d;
    #2;
  endtask

  task automatic idle();
    acc(0, 0, 0, 0, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(10, "reset tim_rd", tim_rd, 16'h0000);
    chk(10, "reset ctrl", {8'h00, ctrl}, 16'h0000);
    chk(10, "reset split", {15'b0, split}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      acc(VECS[i].rd, VECS[i].wr, VECS[i].word, VECS[i].addr, VECS[i].wd);
      chk(VECS[i].req, $sformatf("v%0d drv_rd", i), {15'b0, drd}, {15'b0, VECS[i].drd});
      chk(VECS[i].req, $sformatf("v%0d drv_wr", i), {15'b0, dwr}, {15'b0, VECS[i].dwr});
      chk(VECS[i].req, $sformatf("v%0d wen", i), {12'b0, wen}, {12'b0, VECS[i].wen});
      chk(9, $sformatf("v%0d split", i), {15'b0, split}, {15'b0, VECS[i].split});
      if (VECS[i].rd) chk(VECS[i].req, $sformatf("v%0d rdata", i), rdata, VECS[i].rdat);
    end
    idle();
    // R8 bank layout, R9 split cleared, R7 misc value
    chk(8, "tim_rd banks", tim_rd, 16'hA15A);
    chk(8, "tim_wr banks", tim_wr, 16'hB200);
    chk(9, "ctrl", {8'h00, ctrl}, 16'h0007);
    chk(9, "split cleared", {15'b0, split}, 16'h0000);
    chk(7, "misc", {8'h00, misc}, 16'h0000);

    // R5 strap at 33 MHz
    strap = 1'b0;
    acc(1, 0, 0, 5, 8'h00);
    chk(5, "strap 33MHz", rdata, 16'h0000);
    idle();

    // R10 reset clears everything and closes window
    rst_n = 1'b0;
    repeat (2) idle();
    rst_n = 1'b1;
    idle();
    chk(10, "reset tim_rd", tim_rd, 16'h0000);
    chk(10, "reset tim_wr", tim_wr, 16'h0000);
    chk(10, "reset misc", {8'h00, misc}, 16'h0000);
    acc(1, 0, 0, 0, 8'h00);
    chk(10, "reset locked drv_rd", {15'b0, drd}, 16'h0001);
    chk(10, "reset locked rdata", rdata, DRV);

    // R8 bank B selected but not armed: writes land in bank A
    acc(1, 0, 1, 1, 8'h00);
    acc(1, 0, 1, 1, 8'h00);
    acc(0, 1, 0, 2, 8'h03);
    acc(0, 1, 0, 6, 8'h01);
    acc(0, 1, 0, 0, 8'hC3);
    idle();
    chk(8, "unarmed bank B goes to A", tim_rd, 16'h00C3);

    // R1 idle cycles inside the key are ignored
    acc(0, 1, 0, 2, 8'h83);
    acc(1, 0, 1, 1, 8'h00);
    idle();
    acc(1, 0, 1, 1, 8'h00);
    idle();
    acc(0, 1, 0, 2, 8'h03);
    idle();
    acc(1, 0, 0, 0, 8'h00);
    chk(1, "open after gapped key", rdata, 16'h00C3);
    chk(1, "gapped key no drv_rd", {15'b0, drd}, 16'h0000);
    idle();

    done = 1;
    summary();
  end

endmodule